// File: doc/BRIEF.md
# Scripted Configuration Port Command Engine

This block sits between a command buffer and a 32-bit internal configuration port. A remote user sends a stream of 64-bit command words. The engine takes one word per cycle and turns it into one cycle of port activity. The upper half of each word is the data presented to the port. Three bits of the lower half decide what the port does in that cycle: whether it is selected (active low), whether the transfer is a read, and whether the word closes the session.

The engine never invents pin activity of its own. The sender therefore scripts every enable and direction change, including the deselected cycles that surround a switch from write to read and back. A typical script for reading back a status register has three parts. First, the write phase sends a dummy word, a bus-width pattern, the sync word 0xAA995566, no-op words 0x20000000 and a read header. Then a sequence of control codes turns the port around for the read. Finally, a desync command is written.

Whenever the port is selected for a read, the word the port returns one cycle later is pushed into a readback buffer. When the session-closing word is consumed, the engine raises a one-cycle done pulse.

Top module: `cfgport_cmd_engine`

## Requirements
- R1: While reset is asserted and after its release with an empty command buffer, the port is deselected (`port_ce_n`=1), `port_rw`=0, `port_din`=0, and `cmd_pop`, `rb_push`, `done` and `session_open` are all 0.
- R2: `cmd_pop` is high in a cycle exactly when `cmd_empty`=0 and `rb_afull`=0.
- R3: In the cycle after a pop, the pins show the popped word:
  - `port_din` equals bits [63:32];
  - `port_ce_n` equals bit 24;
  - `port_rw` equals bit 25 (1 = read, 0 = write).
- R4: In the cycle after a cycle without a pop, `port_ce_n` is 1, and `port_rw` and `port_din` keep their previous values.
- R5: For every cycle in which the pins show `port_ce_n`=0 and `port_rw`=1, `rb_push` is high in the next cycle, and `rb_data` carries the `port_dout` value of that next cycle.
- R6: `rb_push` is low in every other cycle. Write cycles and deselected cycles push nothing.
- R7: Popping a word whose bit 26 (last flag) is 1 makes `done` high for the next cycle. `done` is low after any cycle that did not pop such a word.
- R8: `session_open` becomes 1 in the cycle after a pop of a word with bit 26 = 0. It falls to 0 in the cycle after a pop of a word with bit 26 = 1. It holds its value when nothing is popped.
- R9: Bits [23:0] and [31:27] of a command word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_data | input | 64 | Head word of the command buffer (show-ahead) |
| cmd_empty | input | 1 | Command buffer holds no word |
| cmd_pop | output | 1 | Consume the head command word this cycle |
| rb_afull | input | 1 | Readback buffer cannot take two more words |
| rb_push | output | 1 | Write `rb_data` into the readback buffer |
| rb_data | output | 32 | Word read back from the port |
| port_ce_n | output | 1 | Port select, active low |
| port_rw | output | 1 | Port direction, 1 = read |
| port_din | output | 32 | Word presented to the port |
| port_dout | input | 32 | Port output word, registered by the port |
| done | output | 1 | One-cycle pulse after the last word of a session |
| session_open | output | 1 | A session has started and its last word is not yet consumed |

## Verification
The hardest situation to reach is a read turnaround broken up by stalls. In that situation, deselected idle cycles land between the scripted direction-change codes. A read must then still produce exactly one push per selected read cycle, and never one per stall cycle. The stimulus plays the full status-readback script twice: once with a word every cycle, and once with random empty and almost-full gaps inserted between words. After that it sends long streams of random command words whose unused lower bits are filled with random junk. A port stub returns the inverse of the last word written to it, so every read value can be predicted from the script alone.

// File: rtl/cfgport_cmd_engine.sv
module cfgport_cmd_engine #(
  parameter int PAYLOAD_W = 32,
  parameter int CTRL_LSB  = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*PAYLOAD_W-1:0] cmd_data,
  input  logic                   cmd_empty,
  output logic                   cmd_pop,
  input  logic                   rb_afull,
  output logic                   rb_push,
  output logic [PAYLOAD_W-1:0]   rb_data,
  output logic                   port_ce_n,
  output logic                   port_rw,
  output logic [PAYLOAD_W-1:0]   port_din,
  input  logic [PAYLOAD_W-1:0]   port_dout,
  output logic                   done,
  output logic                   session_open
);
  localparam int CMD_W  = 2 * PAYLOAD_W;
  localparam int CE_BIT = CTRL_LSB;
  localparam int RW_BIT = CTRL_LSB + 1;
  localparam int LA_BIT = CTRL_LSB + 2;

  logic                 rd_pend;
  logic [PAYLOAD_W-1:0] word_hi;

  assign cmd_pop = rst_n & ~cmd_empty & ~rb_afull;
  assign word_hi = cmd_data[CMD_W-1:PAYLOAD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_ce_n    <= 1'b1;
      port_rw      <= 1'b0;
      port_din     <= '0;
      done         <= 1'b0;
      session_open <= 1'b0;
      rd_pend      <= 1'b0;
    end else begin
      rd_pend <= ~port_ce_n & port_rw;
      done    <= cmd_pop & cmd_data[LA_BIT];
      if (cmd_pop) begin
        port_ce_n    <= cmd_data[CE_BIT];
        port_rw      <= cmd_data[RW_BIT];
        port_din     <= word_hi;
        session_open <= ~cmd_data[LA_BIT];
      end else begin
        port_ce_n <= 1'b1;
      end
    end
  end

  assign rb_push = rd_pend;
  assign rb_data = port_dout;
endmodule

// File: rtl/cfgport_cmd_engine_chk.sv
module cfgport_cmd_engine_chk #(
  parameter int PAYLOAD_W = 32,
  parameter int CTRL_LSB  = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*PAYLOAD_W-1:0] cmd_data,
  input logic                   cmd_empty,
  input logic                   cmd_pop,
  input logic                   rb_afull,
  input logic                   rb_push,
  input logic                   port_ce_n,
  input logic                   port_rw,
  input logic [PAYLOAD_W-1:0]   port_din,
  input logic                   done,
  input logic                   session_open
);
  assert_pop_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> (!cmd_empty && !rb_afull));

  assert_pins_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |=> (port_din == $past(cmd_data[2*PAYLOAD_W-1:PAYLOAD_W]))
             && (port_ce_n == $past(cmd_data[CTRL_LSB]))
             && (port_rw == $past(cmd_data[CTRL_LSB+1])));

  assert_idle_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_pop |=> port_ce_n && $stable(port_rw) && $stable(port_din));

  assert_push_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_ce_n && port_rw) |=> rb_push);

  assert_no_stray_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ce_n || !port_rw) |=> !rb_push);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop && cmd_data[CTRL_LSB+2]) |=> done && !session_open);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_pop && cmd_data[CTRL_LSB+2]) |=> !done);

  assert_session_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_pop |=> $stable(session_open));
endmodule

bind cfgport_cmd_engine cfgport_cmd_engine_chk #(.PAYLOAD_W(PAYLOAD_W), .CTRL_LSB(CTRL_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_empty(cmd_empty),
  .cmd_pop(cmd_pop), .rb_afull(rb_afull), .rb_push(rb_push),
  .port_ce_n(port_ce_n), .port_rw(port_rw), .port_din(port_din),
  .done(done), .session_open(session_open)
);

// File: tb/tb_cfgport_cmd_engine.sv
module tb_cfgport_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        cmd_empty = 1'b1;
  logic        rb_afull = 1'b0;
  logic        cmd_pop, rb_push, port_ce_n, port_rw, done, session_open;
  logic [31:0] rb_data, port_din;
  logic [31:0] port_dout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfgport_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_empty(cmd_empty),
    .cmd_pop(cmd_pop), .rb_afull(rb_afull), .rb_push(rb_push), .rb_data(rb_data),
    .port_ce_n(port_ce_n), .port_rw(port_rw), .port_din(port_din),
    .port_dout(port_dout), .done(done), .session_open(session_open)
  );

  // port stub: a read returns the inverse of the last written word
  logic [31:0] stub_last;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stub_last <= '0;
      port_dout <= '0;
    end else if (!port_ce_n) begin
      if (port_rw) port_dout <= ~stub_last;
      else         stub_last <= port_din;
    end
  end

  // bench model state
  logic        e_ce_n = 1, e_rw = 0, e_done = 0, e_open = 0, e_push = 0;
  logic [31:0] e_din = '0, e_rbd = '0, m_last = '0;
  int          gap_pct = 0;
  int          afull_pct = 0;
  int          reads_seen = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] hi, input logic [2:0] lrc);
    return {hi, 5'b0, lrc, 24'h0};
  endfunction

  function automatic logic [31:0] stub_read(input logic [31:0] last);
    return ~last;
  endfunction

  // one cycle: check outputs, present inputs, check pop, advance model
  task automatic step(input logic [63:0] w, input bit have, input bit afull, output bit popped);
    bit rd_now, wr_now;
    @(negedge clk);
    chk(port_ce_n === e_ce_n, "R3 R4 R9 ce_n", 64'(port_ce_n), 64'(e_ce_n));
    chk(port_rw === e_rw, "R3 R4 R9 rw", 64'(port_rw), 64'(e_rw));
    chk(port_din === e_din, "R3 R4 din", 64'(port_din), 64'(e_din));
    chk(rb_push === e_push, "R5 R6 rb_push", 64'(rb_push), 64'(e_push));
    if (e_push) begin
      chk(rb_data === e_rbd, "R5 rb_data", 64'(rb_data), 64'(e_rbd));
      reads_seen++;
    end
    chk(done === e_done, "R7 done", 64'(done), 64'(e_done));
    chk(session_open === e_open, "R8 session_open", 64'(session_open), 64'(e_open));
    cmd_data  = w;
    cmd_empty = !have;
    rb_afull  = afull;
    #1;
    popped = have && !afull;
    chk(cmd_pop === popped, "R2 cmd_pop", 64'(cmd_pop), 64'(popped));
    rd_now = !e_ce_n && e_rw;
    wr_now = !e_ce_n && !e_rw;
    e_push = rd_now;
    if (rd_now) e_rbd = stub_read(m_last);
    if (wr_now) m_last = e_din;
    if (popped) begin
      e_ce_n = w[24];
      e_rw   = w[25];
      e_din  = w[63:32];
      e_done = w[26];
      e_open = !w[26];
    end else begin
      e_ce_n = 1'b1;
      e_done = 1'b0;
    end
  endtask

  task automatic send(input logic [63:0] w);
    bit p = 0;
    while (!p) begin
      bit have = ($urandom_range(99) >= gap_pct);
      bit af   = ($urandom_range(99) < afull_pct);
      step(w, have, af, p);
    end
  endtask

  task automatic idle(input int n);
    bit p;
    for (int i = 0; i < n; i++) step($urandom, 1'b0, 1'b0, p);
  endtask

  task automatic status_script();
    send(mk(32'hFFFFFFFF, 3'b000));
    send(mk(32'h000000BB, 3'b000));
    send(mk(32'h11220044, 3'b000));
    send(mk(32'hFFFFFFFF, 3'b000));
    send(mk(32'hAA995566, 3'b000));
    send(mk(32'h20000000, 3'b000));
    send(mk(32'h2800E001, 3'b000));
    send(mk(32'h20000000, 3'b000));
    send(mk(32'h20000000, 3'b000));
    send(mk(32'h00000000, 3'b011));
    send(mk(32'h00000000, 3'b010));
    send(mk(32'h00000000, 3'b001));
    send(mk(32'h30008001, 3'b000));
    send(mk(32'h0000000D, 3'b000));
    send(mk(32'h20000000, 3'b000));
    send(mk(32'h20000000, 3'b100));
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit p;
    int r0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk(port_ce_n === 1'b1 && port_rw === 1'b0 && port_din === 32'h0, "R1 pins in reset",
        {port_ce_n, port_rw, 30'h0, port_din}, {1'b1, 1'b0, 62'h0});
    chk(cmd_pop === 1'b0 && rb_push === 1'b0 && done === 1'b0 && session_open === 1'b0,
        "R1 flags in reset", {cmd_pop, rb_push, done, session_open}, 64'h0);
    rst_n = 1'b1;
    idle(3);

    // directed: status readback, no stalls (one read expected)
    r0 = reads_seen;
    status_script();
    idle(4);
    chk(reads_seen - r0 == 1, "R5 one read in script", 64'(reads_seen - r0), 64'd1);

    // directed: same script with gaps and almost-full stalls
    gap_pct = 40; afull_pct = 30;
    r0 = reads_seen;
    status_script();
    idle(4);
    chk(reads_seen - r0 == 1, "R6 stalls add no reads", 64'(reads_seen - r0), 64'd1);

    // directed: back-to-back last words, consecutive done pulses (R7)
    gap_pct = 0; afull_pct = 0;
    send(mk(32'h12345678, 3'b100));
    send(mk(32'h9ABCDEF0, 3'b110));
    idle(2);

    // directed: junk in unused lower bits must be ignored (R9)
    send({32'hCAFEF00D, 5'b11111, 3'b000, 24'hFFFFFF});
    send({32'h0, 5'b10101, 3'b011, 24'hA5A5A5});
    send({32'h0, 5'b01010, 3'b010, 24'h5A5A5A});
    send({32'h0, 5'b11111, 3'b001, 24'hFFFFFF});
    send({32'h0BADBEEF, 5'b11011, 3'b100, 24'h123456});
    idle(3);

    // random streams with random control bits and stalls
    for (int blk = 0; blk < 20; blk++) begin
      gap_pct   = $urandom_range(50);
      afull_pct = $urandom_range(50);
      for (int k = 0; k < 200; k++) send({$urandom, $urandom});
      idle(2);
    end
    gap_pct = 0; afull_pct = 0;
    idle(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule